// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flags

This block is a purely combinational arithmetic unit that works on 8-, 16- or 32-bit operands. Seven operations share one carry-chain adder: plain add, add with incoming carry, subtract, subtract with incoming borrow, increment, decrement and two's-complement negate. Every operation returns a result together with six status flags: carry, parity, auxiliary carry, zero, sign and overflow.

Subtract-type operations are turned into an addition of the complemented second operand. The adder's carry-out and nibble carry are then inverted to give borrow semantics. Increment and decrement do not touch the carry flag. So the unit also returns an update mask, which tells the surrounding flag register which flag bits to write. Only the low bits of the selected width take part in the arithmetic, and all result bits above that width are forced to zero. A wide add is built by applying plain add to the low word and then add-with-carry to the high word, feeding the first carry flag into the second step.

Top module: `alu_flags_unit`

## Requirements
- R1: Add (op 0) returns a+b, and add with carry (op 1) returns a+b+cf_i, both modulo the selected width. The carry flag (flags_o bit 0) equals the carry out of the selected width's top bit.
- R2: Subtract (op 2) returns a-b, and subtract with borrow (op 3) returns a-b-cf_i. The carry flag is set exactly when a is unsigned-smaller than b (plus cf_i for op 3).
- R3: The overflow flag (bit 5) is set exactly when the signed result of the operation falls outside the signed range of the selected width. For example, 7Fh+1 at 8 bits sets it.
- R4: Increment (op 4) returns a+1 and decrement (op 5) returns a-1. Both output cf_i unchanged on flags_o bit 0 and drive upd_o to 6'b111110. Every other operation drives upd_o to 6'b111111.
- R5: Negate (op 6) returns 0-a and sets carry whenever a is nonzero. Negating 80h at 8 bits returns 80h with carry and overflow both set.
- R6: The auxiliary flag (bit 2) marks a carry out of bit 3 for add-type operations, and a borrow into bit 3 for subtract-type operations (ops 2, 3, 5, 6).
- R7: The sign flag (bit 4) copies the result's top bit at the selected width. The zero flag (bit 3) is set when the masked result is zero.
- R8: The parity flag (bit 1) is set when bits 7:0 of the result hold an even number of ones, at every width.
- R9: Width code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width are zero, and operand bits above it have no effect.
- R10: Op code 7 behaves exactly like plain add.
- R11: A plain add of the low 32-bit words, followed by an add with carry of the high words using the first step's carry flag, yields the 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation: 0 add, 1 add+carry, 2 sub, 3 sub-borrow, 4 inc, 5 dec, 6 neg, 7 add |
| wsel_i | input | 2 | Operand width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| a_i | input | 32 | First operand (destination) |
| b_i | input | 32 | Second operand (source), ignored by inc/dec/neg |
| cf_i | input | 1 | Current carry flag |
| result_o | output | 32 | Result, zero above the selected width |
| flags_o | output | 6 | {overflow, sign, zero, aux, parity, carry} |
| upd_o | output | 6 | Per-flag write enable, same bit order as flags_o |

## Verification
The corners that are hardest to reach are the ones where a narrow width must ignore garbage in the upper operand bits, and where a borrow chain and the incoming carry interact: subtract with borrow on equal operands, and negate of the most negative value. Random operands rarely produce these. The stimulus therefore places the documented edge values (7Fh+1, FFh+1, 26h-95h, 80h negated, zero negated) at each width with random upper bits. It runs subtract-with-borrow on equal operands with both carry inputs, and then sweeps several thousand random vectors over every op and width code against a behavioural model built on signed and unsigned integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int NUM_W  = 3;
  localparam int DATA_W = 8 << (NUM_W - 1);
  localparam int NFLAG  = 6;
  localparam int WSEL_W = 2;

  localparam int FL_CARRY = 0;
  localparam int FL_PAR   = 1;
  localparam int FL_AUX   = 2;
  localparam int FL_ZERO  = 3;
  localparam int FL_SIGN  = 4;
  localparam int FL_OVF   = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_INC = 3'd4, OP_DEC = 3'd5, OP_NEG = 3'd6, OP_RSV = 3'd7
  } alu_op_e;

  // Index of the selected width tap, codes beyond the last clamp to it.
  function automatic int wsel_idx(input logic [WSEL_W-1:0] wsel);
    return (int'(wsel) >= NUM_W) ? NUM_W - 1 : int'(wsel);
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [WSEL_W-1:0] wsel);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < (8 << wsel_idx(wsel))) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic is_sub_op(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC) || (op == OP_NEG);
  endfunction

  // Carry into every bit position; entry DATA_W is the final carry-out.
  function automatic logic [DATA_W:0] ripple_carries(input logic [DATA_W-1:0] x,
                                                     input logic [DATA_W-1:0] y,
                                                     input logic cin);
    logic [DATA_W:0] c;
    c[0] = cin;
    for (int i = 0; i < DATA_W; i++)
      c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
    return c;
  endfunction

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic              cin_o,
  output logic              sub_o,
  output logic              keep_cf_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] m;

  assign op = alu_op_e'(op_i);
  assign m  = width_mask(wsel_i);

  always_comb begin
    x_o   = a_i & m;
    y_o   = b_i & m;
    cin_o = 1'b0;
    unique case (op)
      OP_ADC: cin_o = cf_i;
      OP_SUB: begin y_o = ~b_i & m; cin_o = 1'b1; end
      OP_SBB: begin y_o = ~b_i & m; cin_o = ~cf_i; end
      OP_INC: begin y_o = '0; cin_o = 1'b1; end
      OP_DEC: begin y_o = m; cin_o = 1'b0; end
      OP_NEG: begin x_o = '0; y_o = ~a_i & m; cin_o = 1'b1; end
      default: ;
    endcase
  end

  assign sub_o     = is_sub_op(op);
  assign keep_cf_o = (op == OP_INC) || (op == OP_DEC);

  // Prepared operands never carry bits above the selected width (R9).
  always_comb begin
    assert_prep_in_width_R9: assert (((x_o | y_o) & ~m) == '0);
  end
endmodule

// File: rtl/alu_adder_core.sv
module alu_adder_core
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  input  logic [WSEL_W-1:0] wsel_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_nib_o,
  output logic              c_top_in_o,
  output logic              c_top_out_o
);
  logic [DATA_W:0] c;
  logic [NUM_W-1:0] tap_in, tap_out;

  assign c     = ripple_carries(x_i, y_i, cin_i);
  assign sum_o = x_i ^ y_i ^ c[DATA_W-1:0];
  assign c_nib_o = c[4];

  for (genvar k = 0; k < NUM_W; k++) begin : g_tap
    localparam int TW = 8 << k;
    assign tap_in[k]  = c[TW-1];
    assign tap_out[k] = c[TW];
  end

  assign c_top_in_o  = tap_in[wsel_idx(wsel_i)];
  assign c_top_out_o = tap_out[wsel_idx(wsel_i)];

  // The carry chain agrees with native addition (R1).
  always_comb begin
    assert_ripple_sum_R1: assert ({c[DATA_W], sum_o} ==
                                  ({1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0] sum_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic              c_nib_i,
  input  logic              c_top_in_i,
  input  logic              c_top_out_i,
  input  logic              sub_i,
  input  logic              keep_cf_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [NFLAG-1:0]  upd_o
);
  logic [NUM_W-1:0] msb_tap;
  logic             carry_raw;

  assign res_o = sum_i & width_mask(wsel_i);

  for (genvar k = 0; k < NUM_W; k++) begin : g_msb
    assign msb_tap[k] = res_o[(8 << k) - 1];
  end

  assign carry_raw = c_top_out_i ^ sub_i;

  always_comb begin
    flags_o           = '0;
    flags_o[FL_CARRY] = keep_cf_i ? cf_i : carry_raw;
    flags_o[FL_PAR]   = even_ones(res_o[7:0]);
    flags_o[FL_AUX]   = c_nib_i ^ sub_i;
    flags_o[FL_ZERO]  = (res_o == '0);
    flags_o[FL_SIGN]  = msb_tap[wsel_idx(wsel_i)];
    flags_o[FL_OVF]   = c_top_out_i ^ c_top_in_i;
    upd_o             = '1;
    upd_o[FL_CARRY]   = ~keep_cf_i;
  end

  // A negative result is never zero (R7).
  always_comb begin
    assert_sign_zero_excl_R7: assert (!(flags_o[FL_SIGN] && flags_o[FL_ZERO]));
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [1:0]        wsel_i,
  input  logic [31:0]       a_i,
  input  logic [31:0]       b_i,
  input  logic              cf_i,
  output logic [31:0]       result_o,
  output logic [5:0]        flags_o,
  output logic [5:0]        upd_o
);
  logic [DATA_W-1:0] x, y, sum;
  logic cin, sub_m, keep_cf, c_nib, c_top_in, c_top_out;

  alu_operand_prep i_prep (
    .op_i(op_i), .wsel_i(wsel_i), .a_i(a_i), .b_i(b_i), .cf_i(cf_i),
    .x_o(x), .y_o(y), .cin_o(cin), .sub_o(sub_m), .keep_cf_o(keep_cf)
  );

  alu_adder_core i_add (
    .x_i(x), .y_i(y), .cin_i(cin), .wsel_i(wsel_i), .sum_o(sum),
    .c_nib_o(c_nib), .c_top_in_o(c_top_in), .c_top_out_o(c_top_out)
  );

  alu_flag_gen i_flags (
    .sum_i(sum), .wsel_i(wsel_i), .c_nib_i(c_nib), .c_top_in_i(c_top_in),
    .c_top_out_i(c_top_out), .sub_i(sub_m), .keep_cf_i(keep_cf), .cf_i(cf_i),
    .res_o(result_o), .flags_o(flags_o), .upd_o(upd_o)
  );

  // Port-level checks against the operands seen from outside.
  logic [DATA_W-1:0] wm;
  logic a_top, b_top, r_top, a_nz;
  alu_op_e op_e;
  assign op_e  = alu_op_e'(op_i);
  assign wm    = width_mask(wsel_i);
  assign a_top = |(a_i & wm & ~(wm >> 1));
  assign b_top = |(b_i & wm & ~(wm >> 1));
  assign r_top = |(result_o & wm & ~(wm >> 1));
  assign a_nz  = |(a_i & wm);

  always_comb begin
    assert_upper_zero_R9: assert ((result_o & ~wm) == '0);
    if (op_e == OP_INC || op_e == OP_DEC)
      assert_carry_kept_R4: assert (flags_o[FL_CARRY] == cf_i && !upd_o[FL_CARRY]);
    if (op_e == OP_NEG)
      assert_neg_carry_R5: assert (flags_o[FL_CARRY] == a_nz);
    if (op_e == OP_ADD && flags_o[FL_OVF])
      assert_add_overflow_R3: assert (a_top == b_top && r_top != a_top);
    if (op_e == OP_SUB && flags_o[FL_OVF])
      assert_sub_overflow_R3: assert (a_top != b_top && r_top != a_top);
  end
endmodule

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  op;
  logic [1:0]  ws;
  logic [31:0] a, b;
  logic        cfi;
  logic [31:0] res;
  logic [5:0]  fl, upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alu_flags_unit i_alu_flags_unit (
    .op_i(op), .wsel_i(ws), .a_i(a), .b_i(b), .cf_i(cfi),
    .result_o(res), .flags_o(fl), .upd_o(upd)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] w,
                       input logic [31:0] av, input logic [31:0] bv, input logic c);
    @(posedge clk);
    op = o; ws = w; a = av; b = bv; cfi = c;
    @(negedge clk);
  endtask

  // Behavioural reference: integer arithmetic on masked operands.
  task automatic run(input logic [2:0] o, input logic [1:0] w,
                     input logic [31:0] av, input logic [31:0] bv, input logic c);
    int n; longint m, ua, ub, sa, sb, r, sr, ci, hi, lo;
    longint er; logic ecf, eaf, eof, ezf, esf, epf; logic [5:0] emask;
    string tg;
    apply(o, w, av, bv, c);
    n  = (w >= 2) ? 32 : (8 << w);
    m  = (64'sd1 <<< n) - 1;
    ua = longint'(av) & m; ub = longint'(bv) & m; ci = c ? 1 : 0;
    sa = (ua >= (64'sd1 <<< (n-1))) ? ua - (64'sd1 <<< n) : ua;
    sb = (ub >= (64'sd1 <<< (n-1))) ? ub - (64'sd1 <<< n) : ub;
    emask = 6'h3F;
    case (o)
      3'd1: begin r = ua+ub+ci; ecf = r > m; sr = sa+sb+ci; eaf = ((ua&15)+(ub&15)+ci) > 15; tg = "R1"; end
      3'd2: begin r = ua-ub; ecf = ua < ub; sr = sa-sb; eaf = (ua&15) < (ub&15); tg = "R2"; end
      3'd3: begin r = ua-ub-ci; ecf = ua < ub+ci; sr = sa-sb-ci; eaf = (ua&15) < (ub&15)+ci; tg = "R2"; end
      3'd4: begin r = ua+1; ecf = c; sr = sa+1; eaf = (ua&15) == 15; emask = 6'h3E; tg = "R4"; end
      3'd5: begin r = ua-1; ecf = c; sr = sa-1; eaf = (ua&15) == 0; emask = 6'h3E; tg = "R4"; end
      3'd6: begin r = -ua; ecf = ua != 0; sr = -sa; eaf = (ua&15) != 0; tg = "R5"; end
      default: begin r = ua+ub; ecf = r > m; sr = sa+sb; eaf = ((ua&15)+(ub&15)) > 15;
                     tg = (o == 3'd7) ? "R10" : "R1"; end
    endcase
    er  = r & m;
    hi  = (64'sd1 <<< (n-1)) - 1; lo = -(64'sd1 <<< (n-1));
    eof = (sr > hi) || (sr < lo);
    ezf = (er == 0);
    esf = ((er >>> (n-1)) & 1) != 0;
    epf = ($countones(er[7:0]) % 2) == 0;
    chk(tg,   "result", longint'(res), er);
    chk(tg,   "carry",  longint'(fl[0]), longint'(ecf));
    chk("R3", "overflow", longint'(fl[5]), longint'(eof));
    chk("R6", "aux",    longint'(fl[2]), longint'(eaf));
    chk("R7", "zero",   longint'(fl[3]), longint'(ezf));
    chk("R7", "sign",   longint'(fl[4]), longint'(esf));
    chk("R8", "parity", longint'(fl[1]), longint'(epf));
    chk("R4", "mask",   longint'(upd), longint'(emask));
    chk("R9", "upper",  longint'(res) & ~m, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] x64, y64;
    logic [31:0] lo_r;
    logic        c1;
    op = 0; ws = 0; a = 0; b = 0; cfi = 0;
    // Idle inputs: zero result, zero and parity set (R7, R8)
    apply(3'd0, 2'd0, 32'h0, 32'h0, 1'b0);
    chk("R7", "idle result", longint'(res), 0);
    chk("R7", "idle flags", longint'(fl), 6'b001010);

    // Documented edge values, hand-expected (R1, R2, R3, R5)
    apply(3'd0, 2'd0, 32'hABCD_00FF, 32'h1234_5601, 1'b0);
    chk("R1", "FFh+1 result", longint'(res), 0);
    chk("R1", "FFh+1 flags", longint'(fl), 6'b001111);
    apply(3'd0, 2'd0, 32'h7F, 32'h1, 1'b0);
    chk("R3", "7Fh+1 flags", longint'(fl), 6'b110100);
    apply(3'd2, 2'd0, 32'hFFFF_FF26, 32'h0000_0095, 1'b0);
    chk("R2", "26h-95h result", longint'(res), 32'h91);
    chk("R2", "26h-95h flags", longint'(fl), 6'b110001);
    apply(3'd6, 2'd0, 32'h80, 32'h0, 1'b0);
    chk("R5", "neg 80h result", longint'(res), 32'h80);
    chk("R5", "neg 80h carry/ovf", longint'({fl[5], fl[0]}), 2'b11);
    apply(3'd4, 2'd0, 32'hFF, 32'h0, 1'b1);
    chk("R4", "inc keeps cf", longint'({res[7:0], fl[0]}), 9'h001);

    // Directed corners through the model at every width code
    for (int w = 0; w < 4; w++) begin
      run(3'd0, 2'(w), 32'h7FFF_FFFF, 32'h1, 1'b0);
      run(3'd0, 2'(w), 32'hFFFF_FFFF, 32'h1, 1'b0);
      run(3'd2, 2'(w), 32'h5A5A_5A26, 32'hC3C3_C395, 1'b0);
      run(3'd2, 2'(w), 32'h0, 32'h1, 1'b0);
      run(3'd3, 2'(w), 32'h1234_5678, 32'h1234_5678, 1'b1);
      run(3'd3, 2'(w), 32'h1234_5678, 32'h1234_5678, 1'b0);
      run(3'd1, 2'(w), 32'hFFFF_FFFF, 32'h0, 1'b1);
      run(3'd5, 2'(w), 32'h0, 32'h0, 1'b0);
      run(3'd4, 2'(w), 32'h7FFF_FFFF, 32'h0, 1'b1);
      run(3'd6, 2'(w), 32'h8000_8080, 32'h0, 1'b0);
      run(3'd6, 2'(w), 32'hFFFF_0000 << (8 << (w > 2 ? 2 : w)), 32'h0, 1'b1);
      run(3'd7, 2'(w), 32'h0000_0089, 32'h0000_0077, 1'b0);
    end

    // Chained 64-bit add (R11)
    for (int t = 0; t < 8; t++) begin
      x64 = (t == 0) ? 64'h0000_0001_FFFF_FFFF : {$urandom, $urandom};
      y64 = (t == 0) ? 64'h0000_0002_0000_0001 : {$urandom, $urandom};
      apply(3'd0, 2'd2, x64[31:0], y64[31:0], 1'b0);
      lo_r = res; c1 = fl[0];
      apply(3'd1, 2'd2, x64[63:32], y64[63:32], c1);
      chk("R11", "chained sum", longint'({res, lo_r}), longint'(x64 + y64));
    end

    // Random sweep over all ops and width codes
    for (int i = 0; i < 4000; i++)
      run(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom, $urandom, 1'($urandom));

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule